// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers every interrupt in a companion chip into one status word and one line to the host processor. Four inputs carry the pending summary of four GPIO banks, and six inputs carry the interrupt lines of the other peripherals. Each source is registered into its own bit of a 10-bit status word. The bank flags sit in the low bits and the peripheral lines sit above them. An enable register holds one enable bit per source and a separate master enable. Software reaches both registers through a small 16-bit register port. It reads the status word and then services each pending source.

The host samples the interrupt line on its rising edge. For that reason the output comes from a three-state machine and is not a plain OR of the enabled bits:

- **QUIET**: the line is low. QUIET moves to RAISED when any enabled status bit is set while the master enable is on.
- **RAISED**: the line is high. RAISED moves back to QUIET once no enabled bit remains. It moves to GAP when an enabled bit that was clear in the previous cycle becomes set.
- **GAP**: the line is low for one cycle. GAP moves to RAISED if an enabled bit is still set, and to QUIET otherwise.

The GAP state lets the host see a fresh rising edge for each newly arrived source.

Top module: `irq_status_aggregator`

## Requirements
- R1: After reset the status word reads 0x0000, the enable register reads 0x0000 (master enable off) and `host_irq_o` is low.
- R2: Status bits 3:0 show the bank inputs 3:0, captured at one clock edge and readable after it.
- R3: Status bits 9:4 show the peripheral lines 0..5 in source order. Each bit is captured at one edge, and it clears only at the edge after its line drops.
- R4: Reading the status word (address 0) returns zero in bits 15:10. Reading the enable register (address 1) returns zero in bits 14:10.
- R5: A write to address 1 stores the per-source enables from data bits 9:0 and the master enable from data bit 15. A 1 enables a source and a 0 disables it. The stored value reads back at address 1.
- R6: When a source line rises while its enable bit and the master enable are set, `host_irq_o` goes high after the second clock edge.
- R7: `host_irq_o` stays low while every set status bit has its enable clear, or while the master enable is clear. The status word still reports the pending bits in both cases.
- R8: After the last enabled pending source drops, `host_irq_o` stays high for one more edge and goes low after the second edge.
- R9: If a newly enabled pending bit appears while `host_irq_o` is high, the output goes low for exactly one cycle after the next edge and then high again.
- R10: A write to address 0 changes neither the status word nor the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_pend_i | input | 4 | Pending summary of GPIO banks 0..3 |
| periph_irq_i | input | 6 | Peripheral interrupt lines 0..5 |
| reg_addr_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register (combinational) |
| host_irq_o | output | 1 | Rising-edge interrupt to the host |

## Verification
A table of patterns applies different sets of bank and peripheral inputs together with different enable words. Some patterns have a single bank or a single peripheral pending. One has every source pending with all enables off. In others the master enable is off while the per-source enable is on, or the enable covers a neighbouring bit but not the pending one. Each pattern separates a correct bit position from a shifted or swapped one, and per-source gating from master gating.

Directed tests then step the output cycle by cycle:
- the rise latency after a source line goes high;
- the fall latency after it drops;
- the one-cycle low gap when a second source arrives while the line is high;
- the read-only behaviour of the status address.

// File: rtl/isa_pkg.sv
package isa_pkg;

    // State of the host interrupt line generator
    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_RAISED = 2'd1,
        ST_GAP    = 2'd2
    } irq_state_e;

    // Register select decode
    typedef enum logic {
        ADDR_STATUS = 1'b0,
        ADDR_ENABLE = 1'b1
    } reg_addr_e;

endpackage

// File: rtl/isa_status_capture.sv
module isa_status_capture #(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_PERIPH = 6,
    localparam int NUM_SRC   = NUM_BANKS + NUM_PERIPH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BANKS-1:0]  bank_pend_i,
    input  logic [NUM_PERIPH-1:0] periph_irq_i,
    output logic [NUM_SRC-1:0]    status_o
);

    logic [NUM_SRC-1:0] status_q;

    // Banks occupy the low bits; peripherals follow in source order.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_q[b] <= 1'b0;
            else        status_q[b] <= bank_pend_i[b];
        end
    end

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_q[NUM_BANKS+p] <= 1'b0;
            else        status_q[NUM_BANKS+p] <= periph_irq_i[p];
        end

        // A dropped line must clear its status bit at the next edge.
        AST_PERIPH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !periph_irq_i[p] |=> !status_o[NUM_BANKS+p]); // R3
    end

    assign status_o = status_q;

endmodule

// File: rtl/isa_mask_regs.sv
module isa_mask_regs #(
    parameter int NUM_SRC = 10,
    parameter int DATA_W  = 16,
    parameter int GEN_BIT = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic               gen_o,
    output logic [DATA_W-1:0]  rdback_o
);

    logic [NUM_SRC-1:0] en_q;
    logic               gen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            gen_q <= 1'b0;
        end else if (wr_i) begin
            en_q  <= wdata_i[NUM_SRC-1:0];
            gen_q <= wdata_i[GEN_BIT];
        end
    end

    always_comb begin
        rdback_o              = '0;
        rdback_o[NUM_SRC-1:0] = en_q;
        rdback_o[GEN_BIT]     = gen_q;
    end

    assign en_o  = en_q;
    assign gen_o = gen_q;

    AST_MASTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (gen_o == $past(wdata_i[GEN_BIT]))); // R5

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o)); // R10

endmodule

// File: rtl/isa_edge_fsm.sv
module isa_edge_fsm
    import isa_pkg::*;
#(
    parameter int NUM_SRC = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] act_i,
    output logic               irq_o
);

    irq_state_e         state_q, state_d;
    logic [NUM_SRC-1:0] act_prev_q;
    logic               act_any;
    logic               new_any;

    assign act_any = |act_i;
    assign new_any = |(act_i & ~act_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_QUIET;
            act_prev_q <= '0;
        end else begin
            state_q    <= state_d;
            act_prev_q <= act_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (act_any) state_d = ST_RAISED;
            ST_RAISED: begin
                if (!act_any)     state_d = ST_QUIET;
                else if (new_any) state_d = ST_GAP;
            end
            ST_GAP:    state_d = act_any ? ST_RAISED : ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RAISED: irq_o = 1'b1;
            default:   irq_o = 1'b0;
        endcase
    end

    AST_RAISED_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAISED) |-> $past(act_any)); // R7

    AST_NEW_SOURCE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && new_any) |=> !irq_o); // R9

    AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |=> (state_q != ST_GAP)); // R9

    AST_IDLE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !act_any |=> !irq_o); // R8

endmodule

// File: rtl/irq_status_aggregator.sv
module irq_status_aggregator
    import isa_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_PERIPH = 6,
    parameter int DATA_W     = 16,
    parameter int GEN_BIT    = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BANKS-1:0]  bank_pend_i,
    input  logic [NUM_PERIPH-1:0] periph_irq_i,
    input  logic                  reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    output logic                  host_irq_o
);

    localparam int NUM_SRC = NUM_BANKS + NUM_PERIPH;

    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] en_bits;
    logic               gen;
    logic [NUM_SRC-1:0] act;
    logic [DATA_W-1:0]  mask_rb;
    logic [DATA_W-1:0]  status_rb;
    logic               mask_wr;

    assign mask_wr = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_ENABLE);

    isa_status_capture #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_PERIPH(NUM_PERIPH)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .bank_pend_i (bank_pend_i),
        .periph_irq_i(periph_irq_i),
        .status_o    (status)
    );

    isa_mask_regs #(
        .NUM_SRC(NUM_SRC),
        .DATA_W (DATA_W),
        .GEN_BIT(GEN_BIT)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (reg_wdata_i),
        .en_o    (en_bits),
        .gen_o   (gen),
        .rdback_o(mask_rb)
    );

    // Per-source gating by its own enable and the master enable
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
        assign act[s] = status[s] & en_bits[s] & gen;
    end

    isa_edge_fsm #(
        .NUM_SRC(NUM_SRC)
    ) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .act_i(act),
        .irq_o(host_irq_o)
    );

    always_comb begin
        status_rb              = '0;
        status_rb[NUM_SRC-1:0] = status;
    end

    assign reg_rdata_o = (reg_addr_e'(reg_addr_i) == ADDR_ENABLE) ? mask_rb : status_rb;

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 1'b0) |-> (reg_rdata_o[DATA_W-1:NUM_SRC] == '0)); // R4

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 1'b0) |=> $stable(en_bits)); // R10

    AST_MASTER_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |=> !host_irq_o); // R7

endmodule

// File: tb/sim_irq_status_aggregator.sv
module sim_irq_status_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bank = '0;
    logic [5:0]  periph = '0;
    logic        addr = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    irq_status_aggregator u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bank_pend_i (bank),
        .periph_irq_i(periph),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .host_irq_o  (irq)
    );

    // {bank[3:0], periph[5:0], enable word[15:0], expected irq}
    localparam logic [26:0] VEC [10] = '{
        {4'h0, 6'h00, 16'h83FF, 1'b0},
        {4'h1, 6'h00, 16'h8001, 1'b1},
        {4'h1, 6'h00, 16'h0001, 1'b0},
        {4'h0, 6'h20, 16'h8200, 1'b1},
        {4'h0, 6'h20, 16'h81FF, 1'b0},
        {4'h8, 6'h01, 16'h8010, 1'b1},
        {4'h8, 6'h01, 16'h8008, 1'b1},
        {4'hF, 6'h3F, 16'h0000, 1'b0},
        {4'h5, 6'h0A, 16'h8020, 1'b1},
        {4'h5, 6'h0A, 16'h8040, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic a, input logic [15:0] d);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        step(1);
        wr    = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        reg_read(1'b0, rd); chk("R1 status", rd, 16'h0000);
        reg_read(1'b1, rd); chk("R1 enable", rd, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0000);

        // Table walk: R2 R3 status mapping, R7 gating
        for (int i = 0; i < 10; i++) begin
            logic [26:0] v;
            v = VEC[i];
            bank   = v[26:23];
            periph = v[22:17];
            reg_write(1'b1, v[16:1]);
            step(3);
            reg_read(1'b0, rd);
            chk("R2/R3 status", rd, {6'b0, v[22:17], v[26:23]});
            chk("R7 irq", {15'b0, irq}, {15'b0, v[0]});
        end

        // R4 upper bits and R5 enable readback
        bank = 4'hF; periph = 6'h3F;
        reg_write(1'b1, 16'hFFFF);
        step(1);
        reg_read(1'b0, rd); chk("R4 status upper", rd, 16'h03FF);
        reg_read(1'b1, rd); chk("R4/R5 enable readback", rd, 16'h83FF);

        // R10 write to status address ignored
        bank = 4'h0; periph = 6'h00;
        reg_write(1'b1, 16'h0000);
        step(2);
        reg_write(1'b0, 16'hFFFF);
        step(1);
        reg_read(1'b0, rd); chk("R10 status unchanged", rd, 16'h0000);
        reg_read(1'b1, rd); chk("R10 enable unchanged", rd, 16'h0000);
        chk("R10 irq", {15'b0, irq}, 16'h0000);

        // R6 rise latency
        reg_write(1'b1, 16'h8001);
        step(2);
        bank = 4'h1;
        step(1); chk("R6 irq after first edge", {15'b0, irq}, 16'h0000);
        step(1); chk("R6 irq after second edge", {15'b0, irq}, 16'h0001);

        // R8 fall latency
        bank = 4'h0;
        step(1); chk("R8 irq after first edge", {15'b0, irq}, 16'h0001);
        step(1); chk("R8 irq after second edge", {15'b0, irq}, 16'h0000);

        // R9 fresh edge for a second source
        reg_write(1'b1, 16'h8003);
        bank = 4'h1;
        step(3); chk("R9 irq high", {15'b0, irq}, 16'h0001);
        bank = 4'h3;
        step(1); chk("R9 irq before gap", {15'b0, irq}, 16'h0001);
        step(1); chk("R9 irq gap", {15'b0, irq}, 16'h0000);
        step(1); chk("R9 irq re-raised", {15'b0, irq}, 16'h0001);

        // R3 peripheral bit clears when line drops
        bank = 4'h0;
        periph = 6'h04;
        step(1);
        reg_read(1'b0, rd); chk("R3 periph set", rd, 16'h0040);
        periph = 6'h00;
        step(1);
        reg_read(1'b0, rd); chk("R3 periph cleared", rd, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule